// File: doc/BRIEF.md
# General-Purpose Memory-Mapped Up-Timer

This block is a 32-bit up-counting timer on a word-indexed register bus. The bus has separate read and write strobes. A write takes effect at the clock edge on which the strobe is high. Read data is combinational and valid in the same cycle as the read strobe. The counter advances one step per clock while its start bit is set. When it passes the all-ones value, it restarts from a programmable load value. Whether it then keeps running (periodic) or stops (one-shot) is under software control.

Three events raise sticky pending bits:
- the counter reaching a programmed match value,
- the counter overflowing,
- a selectable trigger event.

Each pending bit is cleared by writing 1 to it. An enable mask chooses which pending bits drive a single level interrupt line. Software can do two further things while the counter runs:
- overwrite the count, or
- force a reload from the load register through a dedicated trigger register.

To get an interrupt about N ticks in the future, software stops the timer, writes 0xFFFFFFFF−N to both the load and count registers, and starts it again.

Top module: `gp_uptimer`

## Requirements
- R1: After reset every stored register reads 0 (count, load, match, mode, enable, pending, wakeup, config) and the interrupt output is low.
- R2: While mode bit 0 (start) is 1 the count grows by exactly 1 per clock. While it is 0 the count holds its value.
- R3: When a running count at 0xFFFFFFFF advances, the next count equals the load value (offset 11) and pending bit 1 (overflow) of the interrupt-status register (offset 6) is set.
- R4: With mode bit 1 (auto-reload) at 0, the overflow also clears the start bit, so the counter stays at the load value.
- R5: With auto-reload at 1, the counter keeps running after an overflow and overflows again every 2^32 − load clocks.
- R6: A write to the count register (offset 10) sets the count on that edge without stopping it. A write of any data to the trigger register (offset 12) copies the load value into the count on that edge.
- R7: With mode bit 6 (compare enable) at 1 and the counter running, a count equal to the match register (offset 14) sets pending bit 0 on the next edge.
- R8: Pending bit 2 is set on overflow when mode bit 10 is 1, and on overflow or match when mode bit 11 is 1. With both bits at 0 it is never set.
- R9: Writing the interrupt-status register clears each pending bit written as 1 and leaves the bits written as 0 unchanged. Pending bits change only through events or such writes.
- R10: The interrupt output is high exactly when some pending bit is also set in the interrupt-enable register (offset 7, same bit layout as the status register).
- R11: Register map: offset 4 keeps only bit 7; offset 8 keeps bits 2:0; offset 5 reads 1; offset 13 and all undefined offsets read 0; offset 9 keeps only bits 0, 1, 6, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (5) | Word index of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid while bus_rd is high, 0 otherwise |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is the overflow edge, because a free-running counter needs about four billion clocks to get there from reset. The bench stops the counter, places the count a few steps below 0xFFFFFFFF through the count register, and counts edges exactly. This lets it see the pending bit stay clear one edge before the wrap and become set on it. The same placement near the top of the range, with a match value one step below the wrap, separates the match-driven and overflow-driven trigger cases within three clocks.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int DW    = 32;
    localparam int AW    = 5;
    localparam int NPEND = 3;

    // Word offsets of the registers
    localparam logic [AW-1:0] OFS_CFG   = AW'(4);
    localparam logic [AW-1:0] OFS_STAT  = AW'(5);
    localparam logic [AW-1:0] OFS_ISR   = AW'(6);
    localparam logic [AW-1:0] OFS_IER   = AW'(7);
    localparam logic [AW-1:0] OFS_WAKE  = AW'(8);
    localparam logic [AW-1:0] OFS_MODE  = AW'(9);
    localparam logic [AW-1:0] OFS_CNT   = AW'(10);
    localparam logic [AW-1:0] OFS_LOAD  = AW'(11);
    localparam logic [AW-1:0] OFS_TRIG  = AW'(12);
    localparam logic [AW-1:0] OFS_WPEND = AW'(13);
    localparam logic [AW-1:0] OFS_MATCH = AW'(14);

    // Pending / enable bit positions
    localparam int PB_MATCH = 0;
    localparam int PB_OVF   = 1;
    localparam int PB_TRIG  = 2;

    // Config register: stored no-idle flag position
    localparam int CFG_NOIDLE_BIT = 7;

    localparam int MODE_W = 12;

    typedef struct packed {
        logic trg_both;  // bit 11
        logic trg_ovf;   // bit 10
        logic cmp_en;    // bit 6
        logic arel;      // bit 1
        logic start;     // bit 0
    } mode_t;

    function automatic mode_t mode_unpack(input logic [MODE_W-1:0] w);
        mode_t m;
        m.start    = w[0];
        m.arel     = w[1];
        m.cmp_en   = w[6];
        m.trg_ovf  = w[10];
        m.trg_both = w[11];
        return m;
    endfunction

    function automatic logic [MODE_W-1:0] mode_pack(input mode_t m);
        logic [MODE_W-1:0] w;
        w     = '0;
        w[0]  = m.start;
        w[1]  = m.arel;
        w[6]  = m.cmp_en;
        w[10] = m.trg_ovf;
        w[11] = m.trg_both;
        return w;
    endfunction

endpackage

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         cmp_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_val,
    input  logic         trig_ld,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         match_evt
);

    logic at_top;

    always_comb begin
        at_top    = &cnt;
        ovf_evt   = run && at_top && !wr_cnt && !trig_ld;
        match_evt = run && cmp_en && (cnt == match_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_cnt) begin
            cnt <= wr_val;
        end else if (trig_ld) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= at_top ? load_val : cnt + W'(1);
        end
    end

endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [N-1:0] en_val,
    output logic [N-1:0] pend,
    output logic [N-1:0] en,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
            end else if (set_evt[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_wr && clr_mask[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else if (en_wr) begin
            en <= en_val;
        end
    end

    assign irq = |(pend & en);

endmodule

// File: rtl/gp_uptimer.sv
module gp_uptimer
    import gpt_pkg::*;
#(
    parameter int DW = gpt_pkg::DW,
    parameter int AW = gpt_pkg::AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);

    localparam int NP = gpt_pkg::NPEND;

    mode_t          mode_q;
    logic           noidle_q;
    logic [NP-1:0]  wake_q;
    logic [DW-1:0]  load_q;
    logic [DW-1:0]  match_q;
    logic [DW-1:0]  cnt_q;
    logic [NP-1:0]  pend_q;
    logic [NP-1:0]  en_q;
    logic           ovf_evt;
    logic           match_evt;
    logic [NP-1:0]  set_evt;

    function automatic logic hit(input logic [AW-1:0] ofs);
        return bus_wr && (bus_addr == ofs);
    endfunction

    gpt_counter #(.W(DW)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .run       (mode_q.start),
        .cmp_en    (mode_q.cmp_en),
        .load_val  (load_q),
        .match_val (match_q),
        .wr_cnt    (hit(OFS_CNT)),
        .wr_val    (bus_wdata),
        .trig_ld   (hit(OFS_TRIG)),
        .cnt       (cnt_q),
        .ovf_evt   (ovf_evt),
        .match_evt (match_evt)
    );

    always_comb begin
        set_evt           = '0;
        set_evt[PB_MATCH] = match_evt;
        set_evt[PB_OVF]   = ovf_evt;
        set_evt[PB_TRIG]  = (mode_q.trg_ovf && ovf_evt) ||
                            (mode_q.trg_both && (ovf_evt || match_evt));
    end

    gpt_irq #(.N(NP)) irq_i (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (set_evt),
        .clr_wr   (hit(OFS_ISR)),
        .clr_mask (bus_wdata[NP-1:0]),
        .en_wr    (hit(OFS_IER)),
        .en_val   (bus_wdata[NP-1:0]),
        .pend     (pend_q),
        .en       (en_q),
        .irq      (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            noidle_q <= 1'b0;
            wake_q   <= '0;
            load_q   <= '0;
            match_q  <= '0;
        end else begin
            if (hit(OFS_MODE)) begin
                mode_q <= mode_unpack(bus_wdata[MODE_W-1:0]);
            end else if (ovf_evt && !mode_q.arel) begin
                mode_q.start <= 1'b0;
            end
            if (hit(OFS_CFG))   noidle_q <= bus_wdata[CFG_NOIDLE_BIT];
            if (hit(OFS_WAKE))  wake_q   <= bus_wdata[NP-1:0];
            if (hit(OFS_LOAD))  load_q   <= bus_wdata;
            if (hit(OFS_MATCH)) match_q  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CFG:   bus_rdata[CFG_NOIDLE_BIT] = noidle_q;
                OFS_STAT:  bus_rdata[0] = 1'b1;
                OFS_ISR:   bus_rdata[NP-1:0] = pend_q;
                OFS_IER:   bus_rdata[NP-1:0] = en_q;
                OFS_WAKE:  bus_rdata[NP-1:0] = wake_q;
                OFS_MODE:  bus_rdata[MODE_W-1:0] = mode_pack(mode_q);
                OFS_CNT:   bus_rdata = cnt_q;
                OFS_LOAD:  bus_rdata = load_q;
                OFS_MATCH: bus_rdata = match_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gp_uptimer_chk.sv
module gp_uptimer_chk #(
    parameter int W  = 32,
    parameter int NP = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic          irq_o,
    input logic [W-1:0]  cnt,
    input logic          run,
    input logic          arel,
    input logic [NP-1:0] pend
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt == '0 && pend == '0 && !irq_o));

    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (run && !bus_wr && !(&cnt)) |=> (cnt == W'($past(cnt) + W'(1))));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !bus_wr) |=> $stable(cnt));

    a_r3_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        (run && !bus_wr && (&cnt)) |=> pend[1]);

    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (run && !arel && !bus_wr && (&cnt)) |=> !run);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> (($past(pend) & ~pend) == '0));

endmodule

bind gp_uptimer gp_uptimer_chk #(.W(DW), .NP(gpt_pkg::NPEND)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .bus_wr (bus_wr),
    .irq_o  (irq_o),
    .cnt    (cnt_q),
    .run    (mode_q.start),
    .arel   (mode_q.arel),
    .pend   (pend_q)
);

// File: tb/gp_uptimer_tb_top.sv
module gp_uptimer_tb_top;

    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gp_uptimer #(.DW(DW), .AW(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Offsets and mode bits taken from the requirements
    localparam logic [AW-1:0] A_CFG = 4, A_STAT = 5, A_ISR = 6, A_IER = 7,
        A_WAKE = 8, A_MODE = 9, A_CNT = 10, A_LOAD = 11, A_TRIG = 12,
        A_WPEND = 13, A_MATCH = 14, A_UNDEF = 20;
    localparam logic [31:0] M_START = 32'h1, M_AREL = 32'h2, M_CMP = 32'h40,
        M_TOVF = 32'h400, M_TBOTH = 32'h800;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write happens on the next rising edge; returns just after it.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    // Read between edges; consumes no edge.
    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        #1;
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CNT, v);   chk("R1 count", v, 0);
        rd(A_MODE, v);  chk("R1 mode", v, 0);
        rd(A_ISR, v);   chk("R1 pending", v, 0);
        rd(A_LOAD, v);  chk("R1 load", v, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_CFG, 32'hFFFF_FFFF);  rd(A_CFG, v);   chk("R11 config", v, 32'h80);
        wr(A_WAKE, 32'hFF);        rd(A_WAKE, v);  chk("R11 wakeup", v, 32'h7);
        rd(A_STAT, v);  chk("R11 status", v, 32'h1);
        rd(A_WPEND, v); chk("R11 write-pending", v, 0);
        rd(A_UNDEF, v); chk("R11 undefined", v, 0);
        wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, v);  chk("R11 mode bits", v, 32'h0C43);
        wr(A_MODE, 0);
        wr(A_IER, 32'hFF);         rd(A_IER, v);   chk("R10 enable bits", v, 32'h7);
        wr(A_IER, 0);
    endtask

    task automatic t_run_hold();
        logic [31:0] a, b;
        wr(A_CNT, 10);
        wr(A_MODE, M_START);
        tick(3);
        rd(A_CNT, a); chk("R2 increment", a, 13);
        wr(A_MODE, 0);
        rd(A_CNT, a);
        tick(5);
        rd(A_CNT, b); chk("R2 hold", b, a);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(A_MODE, 0);
        wr(A_ISR, 7);
        wr(A_LOAD, 32'hFFFF_FFFB);
        wr(A_CNT, 32'hFFFF_FFFB);
        wr(A_MODE, M_START);
        tick(4);
        rd(A_ISR, v);  chk("R3 no overflow yet", v, 0);
        tick(1);
        rd(A_ISR, v);  chk("R3/R8 overflow only", v, 32'h2);
        rd(A_CNT, v);  chk("R3 reload value", v, 32'hFFFF_FFFB);
        rd(A_MODE, v); chk("R4 start cleared", v, 0);
        tick(3);
        rd(A_CNT, v);  chk("R4 holds at load", v, 32'hFFFF_FFFB);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(A_ISR, 7);
        wr(A_LOAD, 32'hFFFF_FFFA);
        wr(A_CNT, 32'hFFFF_FFFA);
        wr(A_MODE, M_START | M_AREL);
        tick(6);
        rd(A_ISR, v);  chk("R5 first overflow", v, 32'h2);
        wr(A_ISR, 32'h2);
        tick(4);
        rd(A_ISR, v);  chk("R5 cleared before second", v, 0);
        tick(1);
        rd(A_ISR, v);  chk("R5 second overflow", v, 32'h2);
        rd(A_MODE, v); chk("R5 still running", v, M_START | M_AREL);
    endtask

    task automatic t_cntwrite();
        logic [31:0] v;
        wr(A_CNT, 32'h1000);
        tick(2);
        rd(A_CNT, v);  chk("R6 count write keeps running", v, 32'h1002);
        wr(A_LOAD, 32'h500);
        wr(A_TRIG, 32'h0);
        rd(A_CNT, v);  chk("R6 trigger reload", v, 32'h500);
        wr(A_MODE, 0);
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(A_ISR, 7);
        wr(A_IER, 32'h1);
        wr(A_MATCH, 100);
        wr(A_CNT, 95);
        wr(A_MODE, M_START | M_CMP | M_TBOTH);
        tick(5);
        rd(A_ISR, v);  chk("R7 no match yet", v, 0);
        chk("R10 irq low", {31'b0, irq_o}, 0);
        tick(1);
        rd(A_ISR, v);  chk("R7/R8 match and trigger", v, 32'h5);
        chk("R10 irq on match", {31'b0, irq_o}, 1);
        wr(A_MODE, 0);
        wr(A_IER, 0);
    endtask

    task automatic t_trig_ovf();
        logic [31:0] v;
        wr(A_ISR, 7);
        wr(A_LOAD, 32'hFFFF_FFFD);
        wr(A_CNT, 32'hFFFF_FFFD);
        wr(A_MATCH, 32'hFFFF_FFFE);
        wr(A_MODE, M_START | M_AREL | M_CMP | M_TOVF);
        tick(2);
        rd(A_ISR, v);  chk("R8 match does not trigger", v, 32'h1);
        tick(1);
        rd(A_ISR, v);  chk("R8 overflow triggers", v, 32'h7);
        wr(A_MODE, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        rd(A_ISR, v);  chk("R9 start state", v, 32'h7);
        wr(A_IER, 32'h2);
        chk("R10 irq overflow enabled", {31'b0, irq_o}, 1);
        wr(A_ISR, 32'h1);
        rd(A_ISR, v);  chk("R9 clear bit0", v, 32'h6);
        wr(A_ISR, 32'h2);
        rd(A_ISR, v);  chk("R9 clear bit1", v, 32'h4);
        chk("R10 irq masked", {31'b0, irq_o}, 0);
        wr(A_ISR, 32'h0);
        rd(A_ISR, v);  chk("R9 zero write no effect", v, 32'h4);
        wr(A_IER, 32'h4);
        chk("R10 irq trigger enabled", {31'b0, irq_o}, 1);
        wr(A_ISR, 32'h7);
        rd(A_ISR, v);  chk("R9 clear all", v, 0);
        chk("R10 irq low after clear", {31'b0, irq_o}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_run_hold();
        t_oneshot();
        t_periodic();
        t_cntwrite();
        t_match();
        t_trig_ovf();
        t_w1c();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule